// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash. It watches single-cycle host write strobes that carry an address and a data word. It recognises the unlock-prefixed command sequences that start a program or an erase, and hands each accepted operation to the array controller as a one-cycle start pulse. The pulse carries the operation kind, the target address and the program data.

An unlock-bypass mode shortens programming to two writes. The mode is entered by a three-write sequence and left by a two-write exit sequence. The unlock addresses are checked differently in word mode and in byte mode. A write that does not fit the current step of a sequence cancels the sequence and starts no operation.

Once an operation has started, the decoder reports busy and ignores all writes. It stays busy until the array controller pulses `op_done`. It then returns to read mode, or to bypass mode if bypass was active.

The start interface is a valid-only stream: `op_valid` is high for exactly one cycle and there is no ready. The array controller must take the start in that cycle. It pushes back only by holding off `op_done`, which keeps the decoder busy. The write strobe is plain and has no back-pressure.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is read (2'b00) and `op_valid` is low.
- R2: Unlock writes compare only the low 12 address bits and the low 8 data bits. In word mode (`byte_mode`=0) the first key address is 555h and the second is 2AAh. In byte mode the first key is AAAh and the second is 555h. The upper address bits are ignored.
- R3: The standard program sequence is four writes: AAh to the first key, 55h to the second key, A0h to the first key, then any address with the program data. On the edge that takes the fourth write, `op_valid` rises with `op_kind`=0 (program) and the address and full data of that write.
- R4: The writes AAh to the first key, 55h to the second key and 20h to the first key put the decoder in bypass mode. `mode` reads 2'b01 from the edge that takes the third write.
- R5: In bypass mode, a write of A0h at any address followed by one more write starts a program of that write's address and data. After `op_done`, the decoder is back in bypass mode.
- R6: Bypass is left only by 90h followed by 00h, at any address, and `mode` then reads 2'b00. If 90h is followed by any other data, the decoder stays in bypass with no operation. In read mode, a bare A0h followed by a write starts nothing.
- R7: The six writes AAh, 55h, 80h, AAh, 55h, 10h, at the first, second, first, first, second and first key, start a chip erase (`op_kind`=1). A 10h at a non-key address in the last step cancels the sequence.
- R8: If the sixth write of the erase sequence is 30h at any address, it starts a block erase (`op_kind`=2). `op_addr` is that address with its low `BLK_LSB` bits (15 by default) cleared.
- R9: Any write whose address or data does not match the current step returns the decoder to its idle state without starting an operation.
- R10: From the start pulse until the edge that takes `op_done`, `mode` reads busy (2'b10) and all writes are ignored.
- R11: `op_valid` lasts exactly one cycle per accepted operation.
- R12: In bypass mode, the erase sequences start nothing and the decoder stays in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects byte-mode unlock keys |
| wr_valid | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W (20) | Write address |
| wr_data | input | DATA_W (16) | Write data; commands use bits 7:0 |
| op_done | input | 1 | Array controller has finished the operation |
| mode | output | 2 | 00 read, 01 bypass, 10 busy |
| op_valid | output | 1 | One-cycle operation start |
| op_kind | output | 2 | 0 program, 1 chip erase, 2 block erase |
| op_addr | output | ADDR_W (20) | Program address or block base address |
| op_data | output | DATA_W (16) | Program data |

## Verification
The first-write data is swept over all 256 values in both addressing modes, and the same is done for the second-write data. This shows that only AAh and then 55h advance the prefix. A sweep of the first-write address over the low 12 bits, in steps of 3 and with fixed upper bits, separates the word-mode key from the byte-mode key and shows that the upper bits are ignored. Directed sequences then cover the four start paths, the erase cancelled by a misplaced 10h, and erase sequences and stray writes in bypass and busy states. These show that each state accepts only its own command.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_UL2, S_PGM, S_ER1, S_ER2, S_ER3,
    S_BP_IDLE, S_BP_PGM, S_BP_EXIT, S_BUSY
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_PROGRAM     = 2'd0,
    OP_CHIP_ERASE  = 2'd1,
    OP_BLOCK_ERASE = 2'd2
  } op_kind_e;

  localparam logic [1:0] MODE_READ   = 2'b00;
  localparam logic [1:0] MODE_BYPASS = 2'b01;
  localparam logic [1:0] MODE_BUSY   = 2'b10;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_BLOCK    = 8'h30;
  localparam logic [7:0] CMD_EXIT_A   = 8'h90;
  localparam logic [7:0] CMD_EXIT_B   = 8'h00;

endpackage

// File: rtl/nor_key_match.sv
`timescale 1ns/1ps
module nor_key_match #(
  parameter int          KEY_W      = 12,
  parameter logic [11:0] WORD_KEY_1 = 12'h555,
  parameter logic [11:0] WORD_KEY_2 = 12'h2AA,
  parameter logic [11:0] BYTE_KEY_1 = 12'hAAA,
  parameter logic [11:0] BYTE_KEY_2 = 12'h555
) (
  input  logic [KEY_W-1:0] addr_lo,
  input  logic             byte_mode,
  output logic             hit_first,
  output logic             hit_second
);
  localparam logic [KEY_W-1:0] WK1 = KEY_W'(WORD_KEY_1);
  localparam logic [KEY_W-1:0] WK2 = KEY_W'(WORD_KEY_2);
  localparam logic [KEY_W-1:0] BK1 = KEY_W'(BYTE_KEY_1);
  localparam logic [KEY_W-1:0] BK2 = KEY_W'(BYTE_KEY_2);

  always_comb begin
    hit_first  = (addr_lo == (byte_mode ? BK1 : WK1));
    hit_second = (addr_lo == (byte_mode ? BK2 : WK2));
  end
endmodule

// File: rtl/nor_seq_fsm.sv
`timescale 1ns/1ps
module nor_seq_fsm
  import nor_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] cmd,
  input  logic       hit_first,
  input  logic       hit_second,
  input  logic       op_done,
  output logic       fire,
  output op_kind_e   fire_kind,
  output logic [1:0] mode
);
  seq_state_e state_q, state_d;
  logic       bypass_q, bypass_d;

  always_comb begin
    state_d   = state_q;
    bypass_d  = bypass_q;
    fire      = 1'b0;
    fire_kind = OP_PROGRAM;
    if (state_q == S_BUSY) begin
      if (op_done) state_d = bypass_q ? S_BP_IDLE : S_IDLE;
    end else if (wr_valid) begin
      unique case (state_q)
        S_IDLE: state_d = (hit_first && cmd == CMD_UNLOCK_A) ? S_UL1 : S_IDLE;
        S_UL1:  state_d = (hit_second && cmd == CMD_UNLOCK_B) ? S_UL2 : S_IDLE;
        S_UL2: begin
          if (hit_first && cmd == CMD_PROGRAM)     state_d = S_PGM;
          else if (hit_first && cmd == CMD_ERASE)  state_d = S_ER1;
          else if (hit_first && cmd == CMD_BYPASS) begin
            state_d  = S_BP_IDLE;
            bypass_d = 1'b1;
          end else                                 state_d = S_IDLE;
        end
        S_PGM, S_BP_PGM: begin
          fire      = 1'b1;
          fire_kind = OP_PROGRAM;
          state_d   = S_BUSY;
        end
        S_ER1: state_d = (hit_first && cmd == CMD_UNLOCK_A) ? S_ER2 : S_IDLE;
        S_ER2: state_d = (hit_second && cmd == CMD_UNLOCK_B) ? S_ER3 : S_IDLE;
        S_ER3: begin
          if (hit_first && cmd == CMD_CHIP) begin
            fire      = 1'b1;
            fire_kind = OP_CHIP_ERASE;
            state_d   = S_BUSY;
          end else if (cmd == CMD_BLOCK) begin
            fire      = 1'b1;
            fire_kind = OP_BLOCK_ERASE;
            state_d   = S_BUSY;
          end else state_d = S_IDLE;
        end
        S_BP_IDLE: begin
          if (cmd == CMD_PROGRAM)     state_d = S_BP_PGM;
          else if (cmd == CMD_EXIT_A) state_d = S_BP_EXIT;
          else                        state_d = S_BP_IDLE;
        end
        S_BP_EXIT: begin
          if (cmd == CMD_EXIT_B) begin
            state_d  = S_IDLE;
            bypass_d = 1'b0;
          end else state_d = S_BP_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      bypass_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bypass_q <= bypass_d;
    end
  end

  always_comb begin
    if (state_q == S_BUSY) mode = MODE_BUSY;
    else if (bypass_q)     mode = MODE_BYPASS;
    else                   mode = MODE_READ;
  end

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUSY && !op_done) |=> (state_q == S_BUSY));

  // R4
  bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_q) |-> ($past(state_q) == S_UL2));

  // R6
  bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_q) |-> ($past(state_q) == S_BP_EXIT));
endmodule

// File: rtl/nor_op_issue.sv
`timescale 1ns/1ps
module nor_op_issue
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  op_kind_e          fire_kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= 2'd0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= fire;
      if (fire) begin
        op_kind <= fire_kind;
        op_addr <= (fire_kind == OP_BLOCK_ERASE) ? (addr & BLK_MASK) : addr;
        op_data <= data;
      end
    end
  end

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  // R8
  block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd2) |-> (op_addr[BLK_LSB-1:0] == '0));
endmodule

// File: rtl/nor_cmd_decoder.sv
`timescale 1ns/1ps
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic [1:0]        mode,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  localparam int KEY_W = 12;

  logic     hit_first, hit_second, fire;
  op_kind_e fire_kind;

  nor_key_match #(.KEY_W(KEY_W)) u_keys (
    .addr_lo   (wr_addr[KEY_W-1:0]),
    .byte_mode (byte_mode),
    .hit_first (hit_first),
    .hit_second(hit_second)
  );

  nor_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .cmd       (wr_data[7:0]),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .op_done   (op_done),
    .fire      (fire),
    .fire_kind (fire_kind),
    .mode      (mode)
  );

  nor_op_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LSB(BLK_LSB)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .fire_kind(fire_kind),
    .addr     (wr_addr),
    .data     (wr_data),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (mode == MODE_BUSY));
endmodule

// File: tb/sim_nor_cmd_decoder.sv
`timescale 1ns/1ps
module sim_nor_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [1:0]  mode;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  nor_cmd_decoder u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  function automatic logic [19:0] k1(input logic bm);
    return {8'h3C, bm ? 12'hAAA : 12'h555};
  endfunction
  function automatic logic [19:0] k2(input logic bm);
    return {8'hC3, bm ? 12'h555 : 12'h2AA};
  endfunction

  // standard program with overridable first step; checks start iff expected
  task automatic try_prog(input string req, input logic bm, input logic [19:0] a1,
                          input logic [7:0] d1, input logic [7:0] d2, input logic exp);
    byte_mode = bm;
    wr(a1, {8'h00, d1});
    wr(k2(bm), {8'h00, d2});
    wr(k1(bm), 16'h00A0);
    wr(20'h1234 ^ {12'h0, d1}, 16'hBEEF);
    chk(req, op_valid, exp);
    if (op_valid) finish_op();
  endtask

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog act=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 2'b00);
    chk("R1 op_valid", op_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 standard program, word mode
    wr(k1(0), 16'h00AA); wr(k2(0), 16'h0055); wr(k1(0), 16'h00A0);
    wr(20'h45678, 16'hBEEF);
    chk("R3 valid", op_valid, 1'b1);
    chk("R3 kind", op_kind, 2'd0);
    chk("R3 addr", op_addr, 20'h45678);
    chk("R3 data", op_data, 16'hBEEF);
    chk("R10 busy", mode, 2'b10);
    @(negedge clk);
    chk("R11 pulse", op_valid, 1'b0);
    // R10 writes ignored while busy
    wr(k1(0), 16'h00AA); wr(k2(0), 16'h0055); wr(k1(0), 16'h0080);
    wr(k1(0), 16'h00AA); wr(k2(0), 16'h0055); wr(k1(0), 16'h0010);
    chk("R10 ignored", op_valid, 1'b0);
    chk("R10 still busy", mode, 2'b10);
    finish_op();
    chk("R10 released", mode, 2'b00);

    // R2 R9 sweep of first and second data
    for (int bm = 0; bm < 2; bm++)
      for (int d = 0; d < 256; d++) begin
        try_prog("R9 first data", bm[0], k1(bm[0]), d[7:0], 8'h55, d == 'hAA);
        try_prog("R9 second data", bm[0], k1(bm[0]), 8'hAA, d[7:0], d == 'h55);
      end
    // R2 sweep of first address
    for (int bm = 0; bm < 2; bm++)
      for (int a = 0; a < 4096; a += 3)
        try_prog("R2 key addr", bm[0], {8'h5A, a[11:0]}, 8'hAA, 8'h55,
                 a == (bm ? 'hAAA : 'h555));

    // R7 chip erase both modes, R8 block erase
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      wr(k1(bm[0]), 16'h00AA); wr(k2(bm[0]), 16'h0055); wr(k1(bm[0]), 16'h0080);
      wr(k1(bm[0]), 16'h00AA); wr(k2(bm[0]), 16'h0055); wr(k1(bm[0]), 16'h0010);
      chk("R7 valid", op_valid, 1'b1);
      chk("R7 kind", op_kind, 2'd1);
      finish_op();
      wr(k1(bm[0]), 16'h00AA); wr(k2(bm[0]), 16'h0055); wr(k1(bm[0]), 16'h0080);
      wr(k1(bm[0]), 16'h00AA); wr(k2(bm[0]), 16'h0055); wr(20'hABCDE, 16'h0030);
      chk("R8 valid", op_valid, 1'b1);
      chk("R8 kind", op_kind, 2'd2);
      chk("R8 addr", op_addr, 20'hA8000);
      finish_op();
      // R7 10h at a non-key address cancels
      wr(k1(bm[0]), 16'h00AA); wr(k2(bm[0]), 16'h0055); wr(k1(bm[0]), 16'h0080);
      wr(k1(bm[0]), 16'h00AA); wr(k2(bm[0]), 16'h0055); wr(20'h00123, 16'h0010);
      chk("R7 misplaced", op_valid, 1'b0);
      chk("R7 mode", mode, 2'b00);
    end
    byte_mode = 1'b0;

    // R9 bad address mid-prefix
    wr(k1(0), 16'h00AA); wr(20'h002AB, 16'h0055); wr(k1(0), 16'h00A0);
    wr(20'h11111, 16'h2222);
    chk("R9 bad addr", op_valid, 1'b0);

    // R4 bypass entry
    wr(k1(0), 16'h00AA); wr(k2(0), 16'h0055); wr(k1(0), 16'h0020);
    chk("R4 mode", mode, 2'b01);
    // R5 bypass program
    wr(20'h77777, 16'h00A0); wr(20'h0F0F0, 16'h5A5A);
    chk("R5 valid", op_valid, 1'b1);
    chk("R5 addr", op_addr, 20'h0F0F0);
    chk("R5 data", op_data, 16'h5A5A);
    finish_op();
    chk("R5 back in bypass", mode, 2'b01);
    // R12 erase ignored in bypass
    wr(k1(0), 16'h00AA); wr(k2(0), 16'h0055); wr(k1(0), 16'h0080);
    wr(k1(0), 16'h00AA); wr(k2(0), 16'h0055); wr(k1(0), 16'h0010);
    chk("R12 no op", op_valid, 1'b0);
    chk("R12 mode", mode, 2'b01);
    // R6 broken exit
    wr(20'h0, 16'h0090); wr(20'h0, 16'h0055);
    chk("R6 stays bypass", mode, 2'b01);
    wr(20'h0, 16'h00A0); wr(20'h00042, 16'h1357);
    chk("R6 bypass program after broken exit", op_valid, 1'b1);
    finish_op();
    // R6 proper exit
    wr(20'h12345, 16'h0090); wr(20'h54321, 16'h0000);
    chk("R6 exit", mode, 2'b00);
    wr(20'h0, 16'h00A0); wr(20'h00042, 16'h1357);
    chk("R6 no short program in read", op_valid, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule